// File: doc/BRIEF.md
# Permanent Bus Master Handover Controller

This block is the one controller on a shared backplane that passes ownership of the bus from one permanent master to another. Software starts a handover by writing to an 8-bit I/O port. The low four bits of the written value name the master that should own the bus next. A read of the same port returns the master that currently owns it.

The controller then runs a fixed sequence:

1. It asks for the bus through the hold/acknowledge handshake and claims the highest arbitration priority. This parks the outgoing master.
2. It broadcasts the incoming master's number on the four arbitration lines.
3. It raises a select strobe. The strobe wakes the incoming master, which then places its own clock on the bus.
4. On the first falling edge of that new clock, it lets go of every line it drove.

The block runs on a fast sampling clock. The bus clock and the hold acknowledge are sampled as levels, and both their edges are detected internally. Because of this, the sequence follows whichever master's clock happens to be on the bus at each step. Each bus line the block can pull is presented as an enable/level pair, and a level output reads 0 whenever its enable is 0.

Top module: `msel_ctrl`

## Requirements
- R1: After reset the current master is 0, `busy` is 0 and every drive enable is 0.
- R2: A port write is accepted only in a sampling-clock cycle where `stat_out`, `sync_in` and `stat_valid` are all 1 and `bus_addr` equals `PORT_ADDR` (default 8'hF0). A write missing any of these leaves `busy` at 0.
- R3: In the cycle after an accepted write, `busy` is 1 and hold is driven low (`hold_oe`=1, `hold_lvl`=0). All four arbitration lines are also driven low (`arb_oe`=4'hF, `arb_lvl`=4'h0), which is priority 15.
- R4: The controller watches for a sampled falling edge of `bus_clk` (sampled 0 after a sampled 1) in a cycle strictly later than the cycle in which `hold_ack` was sampled rising. From the cycle after that falling edge, `arb_lvl` carries the bitwise inverse of the new master number and sync is driven low (`sync_oe`=1, `sync_lvl`=0). Hold stays driven.
- R5: The next sampled rising edge of `bus_clk` has two effects from the following cycle: the select strobe is driven high (`sel_oe`=1, `sel_lvl`=1), and the port read value changes to the new master. The read value changes at no other time.
- R6: The next sampled falling edge of `bus_clk` after the strobe rises releases all lines. In the following cycle every enable is 0 and `busy` is still 1. One cycle later `busy` is 0.
- R7: A port write that arrives while `busy` is 1 is ignored. It neither changes the master that is installed nor starts another handover.
- R8: `rd_data` is always the current master number zero-extended to 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_clk | input | 1 | Sampled level of the bus clock |
| hold_ack | input | 1 | Hold acknowledge, active high |
| stat_out | input | 1 | Output-cycle status |
| sync_in | input | 1 | Bus cycle sync strobe |
| stat_valid | input | 1 | Status-valid qualifier |
| bus_addr | input | 8 | Low I/O address bits |
| wr_data | input | 8 | Data of the port write |
| rd_data | output | 8 | Current master, zero-extended |
| busy | output | 1 | Handover in progress |
| hold_oe | output | 1 | Hold line drive enable |
| hold_lvl | output | 1 | Hold line level (0 = request) |
| arb_oe | output | 4 | Arbitration line drive enables |
| arb_lvl | output | 4 | Arbitration line levels |
| sync_oe | output | 1 | Sync line drive enable |
| sync_lvl | output | 1 | Sync line level |
| sel_oe | output | 1 | Select strobe drive enable |
| sel_lvl | output | 1 | Select strobe level |

## Verification
The bench targets four corner cases:

- **A bus clock edge in the same cycle as the acknowledge rise.** A design that advances on that edge would put the address out one bus phase early.
- **A write issued in the middle of a handover.** A design that relatches on it would install the wrong master or start a second handover.
- **Near-miss writes.** These have one qualifier missing or the wrong port address. A loose decode would start a handover from a read or from another port.
- **The bus clock period changing after the strobe.** This imitates the incoming master's clock. A design that counted cycles instead of watching edges would release too early or too late.

// File: rtl/msel_pkg.sv
package msel_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_HOLD = 3'd1,
    ST_ADDR = 3'd2,
    ST_STRB = 3'd3,
    ST_REL  = 3'd4
  } msel_state_e;

endpackage

// File: rtl/msel_edge.sv
module msel_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);

  logic [W-1:0] lvl_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q[i] <= 1'b0;
      else        lvl_q[i] <= lvl[i];
    end
    assign rise[i] = lvl[i] & ~lvl_q[i];
    assign fall[i] = ~lvl[i] & lvl_q[i];
  end

endmodule

// File: rtl/msel_decode.sv
module msel_decode #(
  parameter int          ADDR_W    = 8,
  parameter int          DATA_W    = 8,
  parameter int          SEL_W     = 4,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 8'hF0
) (
  input  logic              stat_out,
  input  logic              sync_in,
  input  logic              stat_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  cur_sel,
  output logic              wr_hit,
  output logic [SEL_W-1:0]  wr_sel,
  output logic [DATA_W-1:0] rd_data
);

  localparam int PAD_W = DATA_W - SEL_W;

  logic port_match;

  assign port_match = (bus_addr == PORT_ADDR);
  assign wr_hit     = stat_out & sync_in & stat_valid & port_match;
  assign wr_sel     = wr_data[SEL_W-1:0];
  assign rd_data    = {{PAD_W{1'b0}}, cur_sel};

endmodule

// File: rtl/msel_fsm.sv
module msel_fsm
  import msel_pkg::*;
#(
  parameter int SEL_W = 4,
  parameter logic [SEL_W-1:0] BOOT_SEL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic             ack_rise,
  input  logic             bclk_rise,
  input  logic             bclk_fall,
  output msel_state_e      state,
  output logic [SEL_W-1:0] pend_sel,
  output logic [SEL_W-1:0] cur_sel,
  output logic             busy
);

  msel_state_e      state_q, state_d;
  logic             ack_seen_q, ack_seen_d;
  logic [SEL_W-1:0] pend_q, cur_q;
  logic             pend_en, cur_en;

  always_comb begin
    state_d    = state_q;
    ack_seen_d = 1'b0;
    unique case (state_q)
      ST_IDLE: if (wr_hit) state_d = ST_HOLD;
      ST_HOLD: begin
        ack_seen_d = ack_seen_q | ack_rise;
        if (ack_seen_q && bclk_fall) state_d = ST_ADDR;
      end
      ST_ADDR: if (bclk_rise) state_d = ST_STRB;
      ST_STRB: if (bclk_fall) state_d = ST_REL;
      ST_REL:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign pend_en = (state_q == ST_IDLE) && wr_hit;
  assign cur_en  = (state_q == ST_ADDR) && bclk_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      ack_seen_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      ack_seen_q <= ack_seen_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_en) pend_q <= wr_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur_q <= BOOT_SEL;
    else if (cur_en) cur_q <= pend_q;
  end

  assign state    = state_q;
  assign pend_sel = pend_q;
  assign cur_sel  = cur_q;
  assign busy     = (state_q != ST_IDLE);

  // R7
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_hit) |=> $stable(pend_q));

  // R4
  addr_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ADDR && $past(state_q) == ST_HOLD) |-> $past(bclk_fall));

endmodule

// File: rtl/msel_drive.sv
module msel_drive
  import msel_pkg::*;
#(
  parameter int SEL_W = 4
) (
  input  msel_state_e      state,
  input  logic [SEL_W-1:0] pend_sel,
  output logic             hold_oe,
  output logic             hold_lvl,
  output logic [SEL_W-1:0] arb_oe,
  output logic [SEL_W-1:0] arb_lvl,
  output logic             sync_oe,
  output logic             sync_lvl,
  output logic             sel_oe,
  output logic             sel_lvl
);

  logic claim, bcast, strobe;

  assign claim  = (state == ST_HOLD) || (state == ST_ADDR) || (state == ST_STRB);
  assign bcast  = (state == ST_ADDR) || (state == ST_STRB);
  assign strobe = (state == ST_STRB);

  for (genvar i = 0; i < SEL_W; i++) begin : g_arb
    assign arb_oe[i]  = claim;
    assign arb_lvl[i] = bcast & ~pend_sel[i];
  end

  assign hold_oe  = claim;
  assign hold_lvl = 1'b0;
  assign sync_oe  = bcast;
  assign sync_lvl = 1'b0;
  assign sel_oe   = strobe;
  assign sel_lvl  = strobe;

endmodule

// File: rtl/msel_ctrl.sv
module msel_ctrl
  import msel_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          DATA_W    = 8,
  parameter int          SEL_W     = 4,
  parameter logic [7:0]  PORT_ADDR = 8'hF0,
  parameter logic [3:0]  BOOT_SEL  = 4'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_clk,
  input  logic              hold_ack,
  input  logic              stat_out,
  input  logic              sync_in,
  input  logic              stat_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              hold_oe,
  output logic              hold_lvl,
  output logic [SEL_W-1:0]  arb_oe,
  output logic [SEL_W-1:0]  arb_lvl,
  output logic              sync_oe,
  output logic              sync_lvl,
  output logic              sel_oe,
  output logic              sel_lvl
);

  localparam int EDGE_W = 2;
  localparam int E_BCLK = 0;
  localparam int E_ACK  = 1;

  logic [EDGE_W-1:0] e_rise, e_fall;
  logic              wr_hit;
  logic [SEL_W-1:0]  wr_sel, pend_sel, cur_sel;
  msel_state_e       state;

  msel_edge #(.W(EDGE_W)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   ({hold_ack, bus_clk}),
    .rise  (e_rise),
    .fall  (e_fall)
  );

  msel_decode #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .SEL_W     (SEL_W),
    .PORT_ADDR (PORT_ADDR[ADDR_W-1:0])
  ) u_dec (
    .stat_out   (stat_out),
    .sync_in    (sync_in),
    .stat_valid (stat_valid),
    .bus_addr   (bus_addr),
    .wr_data    (wr_data),
    .cur_sel    (cur_sel),
    .wr_hit     (wr_hit),
    .wr_sel     (wr_sel),
    .rd_data    (rd_data)
  );

  msel_fsm #(
    .SEL_W    (SEL_W),
    .BOOT_SEL (BOOT_SEL[SEL_W-1:0])
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_hit    (wr_hit),
    .wr_sel    (wr_sel),
    .ack_rise  (e_rise[E_ACK]),
    .bclk_rise (e_rise[E_BCLK]),
    .bclk_fall (e_fall[E_BCLK]),
    .state     (state),
    .pend_sel  (pend_sel),
    .cur_sel   (cur_sel),
    .busy      (busy)
  );

  msel_drive #(.SEL_W(SEL_W)) u_drv (
    .state    (state),
    .pend_sel (pend_sel),
    .hold_oe  (hold_oe),
    .hold_lvl (hold_lvl),
    .arb_oe   (arb_oe),
    .arb_lvl  (arb_lvl),
    .sync_oe  (sync_oe),
    .sync_lvl (sync_lvl),
    .sel_oe   (sel_oe),
    .sel_lvl  (sel_lvl)
  );

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && stat_out && sync_in && stat_valid && bus_addr == PORT_ADDR[ADDR_W-1:0])
      |=> (busy && hold_oe && arb_oe == '1 && arb_lvl == '0));

  // R5
  rd_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data != $past(rd_data)) |-> $rose(sel_oe));

  // R5
  strobe_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_oe) |-> ($past(sync_oe) && $past(bus_clk) && !$past(e_rise[E_BCLK]) == 1'b0));

  // R6
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_oe) |-> (busy && !sel_oe && !sync_oe && arb_oe == '0 && $past(sel_oe)));

  // R6
  one_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_oe && !sync_oe, !hold_oe && sync_oe, !hold_oe && sel_oe}) &&
    !(sel_oe && !sync_oe) && !(sync_oe && !hold_oe));

endmodule

// File: tb/sim_msel_ctrl.sv
module sim_msel_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_clk = 1'b0;
  logic       hold_ack = 1'b0;
  logic       stat_out = 1'b0, sync_in = 1'b0, stat_valid = 1'b0;
  logic [7:0] bus_addr = 8'h00, wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       busy, hold_oe, hold_lvl, sync_oe, sync_lvl, sel_oe, sel_lvl;
  logic [3:0] arb_oe, arb_lvl;

  int checks = 0;
  int errors = 0;
  int bh = 3;
  int bcnt = 0;
  int ack_dly = 2;
  int hcnt = 0;
  bit done = 0;

  // behavioural reference: phase 0 idle, 1 hold, 2 address, 3 strobe, 4 release
  int m_ph = 0;
  int m_pend = 0;
  int m_cur = 0;
  bit m_ack = 0;
  bit m_bprev = 0;
  bit m_hprev = 0;

  always #4 clk = ~clk;

  msel_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_clk(bus_clk), .hold_ack(hold_ack),
    .stat_out(stat_out), .sync_in(sync_in), .stat_valid(stat_valid),
    .bus_addr(bus_addr), .wr_data(wr_data), .rd_data(rd_data), .busy(busy),
    .hold_oe(hold_oe), .hold_lvl(hold_lvl), .arb_oe(arb_oe), .arb_lvl(arb_lvl),
    .sync_oe(sync_oe), .sync_lvl(sync_lvl), .sel_oe(sel_oe), .sel_lvl(sel_lvl)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // bus clock source; bh may change mid-run to imitate another master's clock
  always @(negedge clk) begin
    if (bcnt >= bh - 1) begin
      bus_clk = ~bus_clk;
      bcnt = 0;
    end else begin
      bcnt++;
    end
  end

  // hold acknowledge responder
  always @(negedge clk) begin
    if (!rst_n) begin
      hold_ack = 1'b0;
      hcnt = 0;
    end else if (hold_oe && !hold_lvl) begin
      if (hcnt >= ack_dly) hold_ack = 1'b1;
      else hcnt++;
    end else begin
      hold_ack = 1'b0;
      hcnt = 0;
    end
  end

  // reference model, advanced at each sampling edge
  always @(posedge clk) begin
    bit wr, br, bf, hr;
    if (!rst_n) begin
      m_ph = 0; m_pend = 0; m_cur = 0; m_ack = 0; m_bprev = 0; m_hprev = 0;
    end else begin
      wr = stat_out && sync_in && stat_valid && bus_addr == 8'hF0;
      br = bus_clk && !m_bprev;
      bf = !bus_clk && m_bprev;
      hr = hold_ack && !m_hprev;
      case (m_ph)
        0: if (wr) begin m_ph = 1; m_pend = wr_data & 8'h0F; m_ack = 0; end
        1: begin
             if (m_ack && bf) m_ph = 2;
             if (hr) m_ack = 1;
           end
        2: if (br) begin m_ph = 3; m_cur = m_pend; end
        3: if (bf) m_ph = 4;
        default: m_ph = 0;
      endcase
      m_bprev = bus_clk;
      m_hprev = hold_ack;
    end
  end

  // every-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit cl, bc;
      cl = (m_ph >= 1 && m_ph <= 3);
      bc = (m_ph == 2 || m_ph == 3);
      chk("R6 busy", busy, m_ph != 0);
      chk("R3 hold", {hold_oe, hold_lvl}, {cl, 1'b0});
      chk("R4 arb", {arb_oe, arb_lvl}, {cl ? 4'hF : 4'h0, bc ? ~m_pend[3:0] : 4'h0});
      chk("R4 sync", {sync_oe, sync_lvl}, {bc, 1'b0});
      chk("R5 sel", {sel_oe, sel_lvl}, {m_ph == 3, m_ph == 3});
      chk("R8 rd", rd_data, m_cur);
    end
  end

  task automatic port_wr(input logic [7:0] a, input logic [7:0] d,
                         input bit so, input bit sy, input bit sv);
    @(negedge clk);
    bus_addr = a; wr_data = d; stat_out = so; sync_in = sy; stat_valid = sv;
    @(negedge clk);
    stat_out = 0; sync_in = 0; stat_valid = 0; bus_addr = 8'h00;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic handover(input logic [7:0] d, input int dly, input int newbh);
    ack_dly = dly;
    port_wr(8'hF0, d, 1, 1, 1);
    chk("R3 busy after write", busy, 1);
    while (!sel_oe && busy) @(negedge clk);
    bh = newbh;
    wait_idle();
    chk("R8 installed master", rd_data, d & 8'h0F);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 rd", rd_data, 0);
    chk("R1 busy", busy, 0);
    chk("R1 enables", {hold_oe, arb_oe, sync_oe, sel_oe}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // near-miss writes
    port_wr(8'hF1, 8'h05, 1, 1, 1);
    port_wr(8'hF0, 8'h05, 0, 1, 1);
    port_wr(8'hF0, 8'h05, 1, 0, 1);
    port_wr(8'hF0, 8'h05, 1, 1, 0);
    repeat (2) @(negedge clk);
    chk("R2 ignored busy", busy, 0);
    chk("R2 ignored rd", rd_data, 0);
    // normal handovers with varied acknowledge delays and clock periods
    handover(8'h05, 2, 5);
    handover(8'hAB, 0, 2);
    handover(8'h3F, 7, 4);
    // write while busy
    ack_dly = 4;
    port_wr(8'hF0, 8'h09, 1, 1, 1);
    repeat (2) @(negedge clk);
    port_wr(8'hF0, 8'h06, 1, 1, 1);
    wait_idle();
    chk("R7 mid-handover write ignored", rd_data, 8'h09);
    repeat (3) @(negedge clk);
    chk("R7 no second handover", busy, 0);
    handover(8'h10, 1, 1);
    handover(8'h0E, 3, 6);
    repeat (4) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule